// File: doc/BRIEF.md
# Block-Handshake HDLC Transmit Pool

This block sits between a host and a bit-level HDLC framer. It buffers outgoing frame bytes in a circular store of `DEPTH` bytes. The host loads bytes and then issues a command that makes them eligible for sending. A send command commits a block. An end command commits the final block of a frame. A reset command abandons everything. The host does not track individual bytes. It waits for a sticky pool-ready interrupt, which says that a whole block of store space has been handed back. The block size is a quarter or a half of the store, chosen by a configuration input.

On the line side, bytes leave through a valid/ready handshake. The first byte of a frame is marked so that the framer prepends an opening flag. The final byte of an ended frame is marked so that the framer appends the check sequence and a closing flag. The block can also pulse an abort request.

A collision reported by the line side is handled in one of two ways:
- If the frame's first block is still held in the store, the read side rewinds to the frame start and sends again with no host involvement.
- Otherwise a repeat interrupt asks the host to resend the whole frame.

A frame that runs dry before its end command is aborted and reported as an underrun. Underrun and repeat both empty the store and lock out host loading until the host acknowledges them.

Top module: `hdlc_txpool`

## Requirements
- R1: After reset, `txValid`, `abortReq`, `irqPool`, `irqUnder` and `irqRepeat` are all low.
- R2: Loaded bytes are not offered on `txValid` until `cmdSend` or `cmdEnd` commits them. Committed bytes are offered from the cycle after the command, in the order they were loaded.
- R3: The first byte of each frame is offered with `txFirst` high. The last byte committed by `cmdEnd` is offered with `txLast` high.
- R4: The block size is `DEPTH/4` bytes when `cfgBigBlk` is 0 and `DEPTH/2` bytes when it is 1. `irqPool` is set when a full block has been accepted downstream, or when a frame's last byte is accepted. It is not set while a partial block of a frame is still held.
- R5: At most `DEPTH` bytes are held. A load while the store is full is ignored.
- R6: An underrun occurs when a frame is open, no committed byte remains and `txReady` is high. On an underrun the store empties, `irqUnder` is set and `abortReq` pulses for one cycle.
- R7: `colDet` during an open frame whose first block is still held rewinds the frame. The frame restarts from its first byte, again marked with `txFirst`, and no interrupt is raised.
- R8: `colDet` during an open frame whose first block has been released sets `irqRepeat` and empties the store, with no `abortReq` pulse.
- R9: While `irqUnder` or `irqRepeat` is set, loads, `cmdSend` and `cmdEnd` are ignored, and no byte is offered.
- R10: `cmdReset` empties the store and cancels pending commands. In the next cycle `abortReq` and `irqPool` are high and `txValid` is low.
- R11: Each interrupt bit stays set until its acknowledge input is pulsed. If a new event arrives in the same cycle as the acknowledge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBigBlk | input | 1 | Block size select: 0 = DEPTH/4, 1 = DEPTH/2 |
| wrEn | input | 1 | Host byte load strobe |
| wrData | input | 8 | Host byte |
| cmdSend | input | 1 | Commit loaded bytes as a non-final block |
| cmdEnd | input | 1 | Commit loaded bytes as the final block of the frame |
| cmdReset | input | 1 | Abandon the store contents and abort |
| ackPool | input | 1 | Clears `irqPool` |
| ackUnder | input | 1 | Clears `irqUnder` |
| ackRepeat | input | 1 | Clears `irqRepeat` |
| irqPool | output | 1 | Sticky: block space released |
| irqUnder | output | 1 | Sticky: frame aborted for lack of data |
| irqRepeat | output | 1 | Sticky: host must resend the frame |
| txValid | output | 1 | A byte is offered to the framer |
| txReady | input | 1 | The framer takes the offered byte |
| txData | output | 8 | Offered byte |
| txFirst | output | 1 | Offered byte opens a frame |
| txLast | output | 1 | Offered byte closes a frame |
| abortReq | output | 1 | One-cycle request to send an abort sequence |
| colDet | input | 1 | Line collision indication |

## Verification
A command registers at the clock edge where it is sampled, so committed bytes show on `txValid` one cycle later. Interrupt bits and `abortReq` likewise appear one cycle after the edge that sees the event. An underrun therefore becomes visible one cycle after the edge that takes the last committed byte. The bench drives inputs one time unit after a rising edge and samples outputs at the falling edge. It puts its direct checks at least one edge after the event that triggers them, and its scoreboard monitor compares each byte at the falling edge before the rising edge that takes it.

// File: rtl/hdlc_txpool_pkg.sv
package hdlc_txpool_pkg;
  // Strobes from the control unit to the store/pointer datapath
  typedef struct packed {
    logic wrByte;    // store host byte at write pointer
    logic commit;    // make loaded bytes visible to the reader
    logic markEnd;   // record frame end position
    logic pop;       // advance read pointer
    logic relBlk;    // hand held space back to the host
    logic rewind;    // restart reading at frame base
    logic flush;     // empty the store
    logic markBase;  // record frame start position
  } dpStrobe_t;
endpackage

// File: rtl/hdlc_txpool_dp.sv
module hdlc_txpool_dp
  import hdlc_txpool_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [7:0]    wrData,
  input  logic [PW-1:0] blkSize,
  output logic [7:0]    rdData,
  output logic          avail,
  output logic          full,
  output logic          atEnd,
  output logic          blkDone,
  output logic          firstHeld
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, commitPtr, endPtr, rdPtr, relPtr, frameBase;
  logic [PW-1:0] wrNext, rdNext;

  assign wrNext    = wrPtr + PW'(stb.wrByte);
  assign rdNext    = rdPtr + PW'(1);
  assign rdData    = mem[rdPtr[AW-1:0]];
  assign avail     = rdPtr != commitPtr;
  assign full      = (wrPtr - relPtr) == PW'(DEPTH);
  assign atEnd     = rdNext == endPtr;
  assign blkDone   = (rdNext - relPtr) == blkSize;
  assign firstHeld = relPtr == frameBase;

  always_ff @(posedge clk) begin
    if (stb.wrByte) mem[wrPtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      endPtr    <= '0;
      rdPtr     <= '0;
      relPtr    <= '0;
      frameBase <= '0;
    end else begin
      wrPtr <= wrNext;
      if (stb.commit)   commitPtr <= wrNext;
      if (stb.markEnd)  endPtr    <= wrNext;
      if (stb.rewind)   rdPtr     <= frameBase;
      else if (stb.pop) rdPtr     <= rdNext;
      if (stb.relBlk)   relPtr    <= rdNext;
      if (stb.markBase) frameBase <= rdPtr;
    end
  end

  // R5: never more than DEPTH bytes between release and write pointers
  assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - relPtr) <= PW'(DEPTH));

  // R2: the reader never runs past committed data
  assert_rd_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr - relPtr) <= (commitPtr - relPtr));
endmodule

// File: rtl/hdlc_txpool_ctrl.sv
module hdlc_txpool_ctrl
  import hdlc_txpool_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgBigBlk,
  input  logic          wrEn,
  input  logic          cmdSend,
  input  logic          cmdEnd,
  input  logic          cmdReset,
  input  logic          ackPool,
  input  logic          ackUnder,
  input  logic          ackRepeat,
  input  logic          colDet,
  input  logic          txReady,
  input  logic          avail,
  input  logic          full,
  input  logic          atEnd,
  input  logic          blkDone,
  input  logic          firstHeld,
  output dpStrobe_t     stb,
  output logic [PW-1:0] blkSize,
  output logic          txValid,
  output logic          txFirst,
  output logic          txLast,
  output logic          abortReq,
  output logic          irqPool,
  output logic          irqUnder,
  output logic          irqRepeat
);
  localparam int SMALL_BLK = DEPTH / 4;
  localparam int LARGE_BLK = DEPTH / 2;

  logic inFrame, endArmed, lock;
  logic colHit, doPop, doUnder, doRepeat, flushNow;

  assign blkSize = cfgBigBlk ? PW'(LARGE_BLK) : PW'(SMALL_BLK);
  assign lock    = irqUnder | irqRepeat;
  assign txValid = avail;
  assign txFirst = avail && !inFrame;
  assign txLast  = avail && endArmed && atEnd;

  always_comb begin
    colHit   = colDet && inFrame && !cmdReset;
    doRepeat = colHit && !firstHeld;
    doPop    = avail && txReady && !cmdReset && !colHit;
    doUnder  = inFrame && !avail && txReady && !cmdReset && !colHit;
    flushNow = cmdReset || doRepeat || doUnder;

    stb          = '0;
    stb.flush    = flushNow;
    stb.rewind   = colHit && firstHeld;
    stb.pop      = doPop;
    stb.markBase = doPop && !inFrame;
    stb.relBlk   = doPop && (blkDone || txLast);
    stb.wrByte   = wrEn && !lock && !full && !flushNow;
    stb.commit   = (cmdSend || cmdEnd) && !lock && !flushNow;
    stb.markEnd  = cmdEnd && !lock && !flushNow && !endArmed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      endArmed  <= 1'b0;
      abortReq  <= 1'b0;
      irqPool   <= 1'b0;
      irqUnder  <= 1'b0;
      irqRepeat <= 1'b0;
    end else begin
      abortReq <= cmdReset || doUnder;

      if (flushNow || stb.rewind) inFrame <= 1'b0;
      else if (doPop)             inFrame <= !txLast;

      if (flushNow)              endArmed <= 1'b0;
      else if (doPop && txLast)  endArmed <= 1'b0;
      else if (stb.markEnd)      endArmed <= 1'b1;

      if (stb.relBlk || cmdReset) irqPool <= 1'b1;
      else if (ackPool)           irqPool <= 1'b0;

      if (doUnder)        irqUnder <= 1'b1;
      else if (ackUnder)  irqUnder <= 1'b0;

      if (doRepeat)       irqRepeat <= 1'b1;
      else if (ackRepeat) irqRepeat <= 1'b0;
    end
  end

  // R9: nothing is offered while an underrun or repeat is pending
  assert_lock_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqUnder || irqRepeat) |-> !txValid);

  // R6: an underrun always comes with an abort request
  assert_under_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqUnder) |-> abortReq);

  // R8: a repeat request never aborts
  assert_repeat_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqRepeat) |-> !abortReq);

  // R7: a rewind re-offers the frame start at once
  assert_rewind_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (colDet && inFrame && firstHeld && !cmdReset) |=> (txValid && txFirst && !irqRepeat));

  // R10: reset command aborts, empties and signals pool ready
  assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |=> (abortReq && irqPool && !txValid));
endmodule

// File: rtl/hdlc_txpool.sv
module hdlc_txpool
  import hdlc_txpool_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgBigBlk,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       cmdSend,
  input  logic       cmdEnd,
  input  logic       cmdReset,
  input  logic       ackPool,
  input  logic       ackUnder,
  input  logic       ackRepeat,
  output logic       irqPool,
  output logic       irqUnder,
  output logic       irqRepeat,
  output logic       txValid,
  input  logic       txReady,
  output logic [7:0] txData,
  output logic       txFirst,
  output logic       txLast,
  output logic       abortReq,
  input  logic       colDet
);
  localparam int PW = $clog2(DEPTH) + 1;

  dpStrobe_t     stb;
  logic [PW-1:0] blkSize;
  logic          avail, full, atEnd, blkDone, firstHeld;

  hdlc_txpool_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgBigBlk(cfgBigBlk), .wrEn(wrEn),
    .cmdSend(cmdSend), .cmdEnd(cmdEnd), .cmdReset(cmdReset),
    .ackPool(ackPool), .ackUnder(ackUnder), .ackRepeat(ackRepeat),
    .colDet(colDet), .txReady(txReady),
    .avail(avail), .full(full), .atEnd(atEnd), .blkDone(blkDone), .firstHeld(firstHeld),
    .stb(stb), .blkSize(blkSize),
    .txValid(txValid), .txFirst(txFirst), .txLast(txLast), .abortReq(abortReq),
    .irqPool(irqPool), .irqUnder(irqUnder), .irqRepeat(irqRepeat)
  );

  hdlc_txpool_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .blkSize(blkSize),
    .rdData(txData), .avail(avail), .full(full), .atEnd(atEnd),
    .blkDone(blkDone), .firstHeld(firstHeld)
  );
endmodule

// File: tb/hdlc_txpool_tb.sv
module hdlc_txpool_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN, cfgBigBlk, wrEn, cmdSend, cmdEnd, cmdReset;
  logic ackPool, ackUnder, ackRepeat, txReady, colDet;
  logic [7:0] wrData, txData;
  logic irqPool, irqUnder, irqRepeat, txValid, txFirst, txLast, abortReq;

  int nChecks = 0;
  int nFails = 0;
  int abortSeen = 0;
  bit locked = 1'b0;
  bit frameOpen = 1'b0;
  logic [7:0] pendQ[$];
  logic [9:0] expQ[$];   // {first, last, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_txpool #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .cfgBigBlk(cfgBigBlk), .wrEn(wrEn), .wrData(wrData),
    .cmdSend(cmdSend), .cmdEnd(cmdEnd), .cmdReset(cmdReset),
    .ackPool(ackPool), .ackUnder(ackUnder), .ackRepeat(ackRepeat),
    .irqPool(irqPool), .irqUnder(irqUnder), .irqRepeat(irqRepeat),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .txFirst(txFirst), .txLast(txLast), .abortReq(abortReq), .colDet(colDet)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic hostWrite(int n, int seed);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1;
      wrData = pat(seed, i);
      if (!locked && (pendQ.size() + expQ.size()) < DEPTH) pendQ.push_back(pat(seed, i));
      tick(1);
    end
    wrEn = 1'b0;
  endtask

  task automatic hostCmd(bit isEnd);
    if (isEnd) cmdEnd = 1'b1; else cmdSend = 1'b1;
    if (!locked) begin
      while (pendQ.size() > 0) begin
        logic [7:0] b;
        logic f, l;
        b = pendQ.pop_front();
        f = !frameOpen;
        frameOpen = 1'b1;
        l = isEnd && (pendQ.size() == 0);
        if (l) frameOpen = 1'b0;
        expQ.push_back({f, l, b});
      end
    end
    pendQ.delete();
    tick(1);
    cmdSend = 1'b0;
    cmdEnd = 1'b0;
  endtask

  task automatic pulseAck(int which);
    if (which == 0) ackPool = 1'b1;
    else if (which == 1) ackUnder = 1'b1;
    else ackRepeat = 1'b1;
    tick(1);
    ackPool = 1'b0; ackUnder = 1'b0; ackRepeat = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compare each accepted byte against the queue
  always @(negedge clk) begin
    if (rstN && abortReq) abortSeen++;
    if (rstN && txValid && txReady && !colDet && !cmdReset) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R2 unexpected byte: actual %0h expected none", txData);
      end else begin
        logic [9:0] e;
        e = expQ.pop_front();
        chk("R2 byte data", 32'(txData), 32'(e[7:0]));
        chk("R3 first mark", 32'(txFirst), 32'(e[9]));
        chk("R3 last mark", 32'(txLast), 32'(e[8]));
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int a0;
    rstN = 1'b0; cfgBigBlk = 1'b0; wrEn = 1'b0; wrData = '0;
    cmdSend = 1'b0; cmdEnd = 1'b0; cmdReset = 1'b0;
    ackPool = 1'b0; ackUnder = 1'b0; ackRepeat = 1'b0;
    txReady = 1'b0; colDet = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 abortReq", 32'(abortReq), 0);
    chk("R1 irqPool", 32'(irqPool), 0);
    chk("R1 irqUnder", 32'(irqUnder), 0);
    chk("R1 irqRepeat", 32'(irqRepeat), 0);

    // R2 R3 R4: short frame, small blocks
    hostWrite(10, 3);
    chk("R2 held until commit", 32'(txValid), 0);
    hostCmd(1);
    chk("R2 offered after commit", 32'(txValid), 1);
    txReady = 1'b1;
    drain();
    tick(2);
    chk("R4 pool on frame end", 32'(irqPool), 1);
    txReady = 1'b0;
    pulseAck(0);
    chk("R11 pool ack", 32'(irqPool), 0);

    // R5: overfill, only DEPTH bytes kept
    hostWrite(70, 11);
    chk("R2 nothing offered uncommitted", 32'(txValid), 0);
    hostCmd(1);
    txReady = 1'b1;
    drain();
    tick(2);
    chk("R5 no bytes beyond capacity", 32'(txValid), 0);
    txReady = 1'b0;
    pulseAck(0);

    // R7: collision while first block held
    hostWrite(8, 40);
    hostCmd(1);
    txReady = 1'b1;
    tick(3);
    txReady = 1'b0;
    chk("R7 three bytes taken", 32'(expQ.size()), 5);
    colDet = 1'b1;
    tick(1);
    colDet = 1'b0;
    expQ.delete();
    for (int i = 0; i < 8; i++) expQ.push_back({(i == 0), (i == 7), pat(40, i)});
    chk("R7 restart marked first", 32'(txFirst), 1);
    chk("R7 no repeat irq", 32'(irqRepeat), 0);
    txReady = 1'b1;
    drain();
    tick(2);
    chk("R4 pool after rewound frame", 32'(irqPool), 1);
    txReady = 1'b0;
    pulseAck(0);

    // R8 R9: collision after first block released
    hostWrite(20, 90);
    hostCmd(0);
    txReady = 1'b1;
    tick(18);
    txReady = 1'b0;
    chk("R4 small block released", 32'(irqPool), 1);
    a0 = abortSeen;
    colDet = 1'b1;
    tick(1);
    colDet = 1'b0;
    expQ.delete();
    frameOpen = 1'b0;
    locked = 1'b1;
    chk("R8 repeat irq", 32'(irqRepeat), 1);
    chk("R8 store emptied", 32'(txValid), 0);
    tick(2);
    chk("R8 no abort", 32'(abortSeen), 32'(a0));
    hostWrite(4, 5);
    hostCmd(0);
    tick(1);
    chk("R9 locked writes ignored", 32'(txValid), 0);
    pulseAck(2);
    locked = 1'b0;
    chk("R11 repeat ack", 32'(irqRepeat), 0);
    pulseAck(0);

    // R6 R4: underrun with large blocks, no release
    cfgBigBlk = 1'b1;
    a0 = abortSeen;
    hostWrite(20, 120);
    hostCmd(0);
    txReady = 1'b1;
    drain();
    tick(3);
    chk("R6 underrun irq", 32'(irqUnder), 1);
    chk("R6 one abort pulse", 32'(abortSeen), 32'(a0 + 1));
    chk("R6 store emptied", 32'(txValid), 0);
    chk("R4 partial large block held", 32'(irqPool), 0);
    txReady = 1'b0;
    frameOpen = 1'b0;
    locked = 1'b1;
    hostWrite(5, 7);
    hostCmd(1);
    chk("R9 underrun lock", 32'(txValid), 0);
    pulseAck(1);
    locked = 1'b0;
    chk("R11 underrun ack", 32'(irqUnder), 0);
    hostWrite(3, 200);
    hostCmd(1);
    txReady = 1'b1;
    drain();
    tick(2);
    chk("R4 pool after short frame", 32'(irqPool), 1);
    txReady = 1'b0;
    pulseAck(0);

    // R10: reset command
    cfgBigBlk = 1'b0;
    hostWrite(5, 60);
    hostCmd(0);
    a0 = abortSeen;
    cmdReset = 1'b1;
    tick(1);
    cmdReset = 1'b0;
    expQ.delete();
    frameOpen = 1'b0;
    chk("R10 abort request", 32'(abortReq), 1);
    chk("R10 pool ready", 32'(irqPool), 1);
    chk("R10 store emptied", 32'(txValid), 0);
    tick(1);
    chk("R10 single abort pulse", 32'(abortSeen), 32'(a0 + 1));
    pulseAck(0);
    hostWrite(4, 77);
    hostCmd(1);
    txReady = 1'b1;
    drain();
    tick(2);
    chk("R10 clean frame after reset", 32'(expQ.size()), 0);
    txReady = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule